// File: doc/BRIEF.md
# Cube-Map Face Coordinate Unit

This unit takes a three-component direction vector, each component a raw 32-bit word read as an IEEE-754 single-precision value, and works out which cube face the vector points at. A 2-bit function select then picks one of three results for that face: the doubled major-axis component, the S face coordinate, or the T face coordinate. A texture-address stage issues one such request for each coordinate it needs.

The arithmetic is done entirely on bit patterns. Magnitudes are compared as unsigned integers on the bits below the sign. A sign multiply is an XOR on the sign bit. The doubling adds one to the exponent field. No floating-point multiplier is used. The result is registered once: a request presented with `in_valid` high appears on `res_data`, qualified by `out_valid`, on the following clock edge.

Top module: `cube_face_unit`

## Requirements
- R1: The face is chosen by comparing bits [30:0] of each component as unsigned integers. z wins if its magnitude is at least that of both y and x. Otherwise y wins if it is at least that of x. Otherwise x wins. Ties therefore go first to z and then to y.
- R2: With function select 0, the result is the selected component doubled with its sign kept. For a normal input with exponent 1..253, the exponent field (bits [30:23]) rises by one and the mantissa is unchanged.
- R3: In the doubling, an exponent of 254 saturates to an infinity of the same sign (0x7F800000 or 0xFF800000). An exponent of 255 (infinity or NaN) passes through unchanged.
- R4: In the doubling, a zero stays zero with its sign, and a denormal (exponent 0) has bits [30:0] shifted left by one, so its top mantissa bit carries into the exponent.
- R5: With function select 1 (S), the result is built per face. For face z it is x with its sign XORed with the sign of z. For face y it is x unchanged. For face x it is z with its sign XORed with the inverted sign of x.
- R6: With function select 2 (T), the result is y with its sign bit inverted for faces z and x. For face y it is z with its sign XORed with the sign of y.
- R7: A component whose bits [30:0] are zero counts as positive when its sign drives an S or T result, even if its sign bit is 1.
- R8: Function select 3 gives a result of 0x00000000 whatever the operands are.
- R9: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `res_data` carries that request's result. Synchronous active-low reset clears both to zero.
- R10: While `in_valid` is low, `res_data` holds its last value whatever the operand and select inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe; operands and select are taken when high |
| vec_x | input | 32 | x component (single-precision bit pattern) |
| vec_y | input | 32 | y component (single-precision bit pattern) |
| vec_z | input | 32 | z component (single-precision bit pattern) |
| func_sel | input | 2 | 0 doubled major axis, 1 S coordinate, 2 T coordinate, 3 zero |
| out_valid | output | 1 | High one cycle after an accepted request |
| res_data | output | 32 | Registered result word |

## Verification
The bench targets equal magnitudes carried by components of opposite sign. A design that resolves ties in the wrong order, or that compares signed values, would pick the wrong face and return the other sign.

It covers several doubling edge cases:
- an exponent of 254, where an adder that is not guarded wraps into a NaN pattern instead of an infinity;
- infinities and NaNs, which must not be changed;
- denormals, which must shift left and carry into the exponent rather than having their exponent bumped.

It feeds a negative zero as the component whose sign drives S. A design that reads the sign bit without testing for zero would flip the output sign. Select value 3 and the hold behaviour while idle are checked at the output word.

// File: rtl/cube_pkg.sv
// Shared types for the cube-map face coordinate unit.
// Assumes IEEE-754 style words: sign in the top bit, then exponent, then mantissa.
package cube_pkg;

    // Function select encoding seen at the top-level port
    typedef enum logic [1:0] {
        FN_MAJOR = 2'd0,
        FN_S     = 2'd1,
        FN_T     = 2'd2,
        FN_NONE  = 2'd3
    } cube_fn_e;

    // One-hot winning face
    typedef struct packed {
        logic ax_x;
        logic ax_y;
        logic ax_z;
    } face_t;

endpackage

// File: rtl/cube_face_sel.sv
// Picks the major axis from three magnitudes (sign bits already stripped).
// Assumes the magnitudes compare as unsigned integers; ties go to z, then y.
module cube_face_sel
    import cube_pkg::*;
#(
    parameter int unsigned MAG_W = 31
) (
    input  logic [MAG_W-1:0] mag_x,
    input  logic [MAG_W-1:0] mag_y,
    input  logic [MAG_W-1:0] mag_z,
    output face_t            face
);

    logic z_ge_y, z_ge_x, y_ge_x;

    // Pairwise magnitude compares and priority resolution
    always_comb begin
        z_ge_y     = (mag_z >= mag_y);
        z_ge_x     = (mag_z >= mag_x);
        y_ge_x     = (mag_y >= mag_x);
        face.ax_z  = z_ge_y & z_ge_x;
        face.ax_y  = ~face.ax_z & y_ge_x;
        face.ax_x  = ~face.ax_z & ~face.ax_y;
    end

    // A lower-priority winner must beat the higher-priority ones strictly
    always_comb begin
        if (face.ax_x) begin
            p_x_strict_r1: assert (mag_x > mag_y && mag_x > mag_z);
        end
        if (face.ax_y) begin
            p_y_strict_r1: assert (mag_y > mag_z && mag_y >= mag_x);
        end
    end

endmodule

// File: rtl/cube_fp_double.sv
// Doubles a floating-point word by exponent increment, without a multiplier.
// Assumes: a max exponent (inf/NaN) passes through, the largest finite exponent
// saturates to a signed infinity, zero stays zero, a denormal shifts left by one.
module cube_fp_double #(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] op,
    output logic [EXP_W+MAN_W:0] dbl
);

    localparam int unsigned W     = EXP_W + MAN_W + 1;
    localparam logic [EXP_W-1:0] EXP_MAX = '1;
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_MAX - 1'b1;

    logic             sgn;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;

    // Field split and doubling by case on the exponent
    always_comb begin
        sgn  = op[W-1];
        expo = op[W-2:MAN_W];
        man  = op[MAN_W-1:0];
        if (expo == EXP_MAX) begin
            dbl = op;
        end else if (expo == '0) begin
            dbl = {sgn, op[W-3:0], 1'b0};
        end else if (expo == EXP_TOP) begin
            dbl = {sgn, EXP_MAX, {MAN_W{1'b0}}};
        end else begin
            dbl = {sgn, expo + 1'b1, man};
        end
    end

    // Sign never changes; a nonzero finite value always grows in magnitude
    always_comb begin
        p_sign_kept_r2: assert (dbl[W-1] == op[W-1]);
        if (expo != EXP_MAX && op[W-2:0] != '0) begin
            p_grows_r2: assert (dbl[W-2:0] > op[W-2:0]);
        end
    end

endmodule

// File: rtl/cube_coord_mux.sv
// Forms the doubled major value, S and T for the chosen face and picks one by
// function select. Sign multiplies are sign-bit XORs; a zero counts as positive.
module cube_coord_mux
    import cube_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] vx,
    input  logic [EXP_W+MAN_W:0] vy,
    input  logic [EXP_W+MAN_W:0] vz,
    input  face_t                face,
    input  cube_fn_e             fn,
    output logic [EXP_W+MAN_W:0] res
);

    localparam int unsigned W = EXP_W + MAN_W + 1;

    logic [W-1:0] major, major_x2, s_val, t_val;
    logic         neg_x, neg_y, neg_z;

    // Effective signs: negative only when the magnitude is nonzero
    always_comb begin
        neg_x = vx[W-1] & (|vx[W-2:0]);
        neg_y = vy[W-1] & (|vy[W-2:0]);
        neg_z = vz[W-1] & (|vz[W-2:0]);
    end

    // Major component selection
    always_comb begin
        if (face.ax_z)      major = vz;
        else if (face.ax_y) major = vy;
        else                major = vx;
    end

    cube_fp_double #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dbl (
        .op  (major),
        .dbl (major_x2)
    );

    // Per-face S and T formation
    always_comb begin
        if (face.ax_z) begin
            s_val = {vx[W-1] ^ neg_z, vx[W-2:0]};
            t_val = {~vy[W-1], vy[W-2:0]};
        end else if (face.ax_y) begin
            s_val = vx;
            t_val = {vz[W-1] ^ neg_y, vz[W-2:0]};
        end else begin
            s_val = {vz[W-1] ^ ~neg_x, vz[W-2:0]};
            t_val = {~vy[W-1], vy[W-2:0]};
        end
    end

    // Function select output mux
    always_comb begin
        unique case (fn)
            FN_MAJOR: res = major_x2;
            FN_S:     res = s_val;
            FN_T:     res = t_val;
            default:  res = '0;
        endcase
    end

    // S and T only ever carry the magnitude of an input component
    always_comb begin
        if (fn == FN_S) begin
            p_s_source_r5: assert (res[W-2:0] == vx[W-2:0] || res[W-2:0] == vz[W-2:0]);
        end
        if (fn == FN_T) begin
            p_t_source_r6: assert (res[W-2:0] == vy[W-2:0] || res[W-2:0] == vz[W-2:0]);
        end
    end

endmodule

// File: rtl/cube_face_unit.sv
// Cube-map face coordinate unit, one registered stage.
// Assumes operands are raw single-precision words; in_valid qualifies a request.
module cube_face_unit
    import cube_pkg::*;
#(
    parameter int unsigned EXP_W = 8,
    parameter int unsigned MAN_W = 23,
    localparam int unsigned W    = EXP_W + MAN_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] vec_x,
    input  logic [W-1:0] vec_y,
    input  logic [W-1:0] vec_z,
    input  logic [1:0]   func_sel,
    output logic         out_valid,
    output logic [W-1:0] res_data
);

    face_t        face;
    logic [W-1:0] res_comb;
    logic [W-1:0] res_q;
    logic         vld_q;

    cube_face_sel #(.MAG_W(W-1)) u_sel (
        .mag_x (vec_x[W-2:0]),
        .mag_y (vec_y[W-2:0]),
        .mag_z (vec_z[W-2:0]),
        .face  (face)
    );

    cube_coord_mux #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mux (
        .vx   (vec_x),
        .vy   (vec_y),
        .vz   (vec_z),
        .face (face),
        .fn   (cube_fn_e'(func_sel)),
        .res  (res_comb)
    );

    // Output stage: load result on a request, mark it valid for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= res_comb;
        end
    end

    assign out_valid = vld_q;
    assign res_data  = res_q;

    p_valid_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_data));
    p_none_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == 2'd3) |=> (res_data == '0));
    p_major_ge_x_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == 2'd0) |=> (res_data[W-2:0] >= $past(vec_x[W-2:0])));
    p_major_ge_z_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && func_sel == 2'd0) |=> (res_data[W-2:0] >= $past(vec_z[W-2:0])));

endmodule

// File: tb/sim_cube_face_unit.sv
// Scoreboard bench: the driver queues expected words, the monitor pops and compares.
module sim_cube_face_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] vec_x = '0, vec_y = '0, vec_z = '0;
    logic [1:0]  func_sel = '0;
    logic        out_valid;
    logic [31:0] res_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    cube_face_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .vec_x(vec_x), .vec_y(vec_y), .vec_z(vec_z),
        .func_sel(func_sel), .out_valid(out_valid), .res_data(res_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Independent reference from the requirement text
    function automatic logic [31:0] dbl_ref(input logic [31:0] v);
        logic [7:0] e;
        e = v[30:23];
        if (e == 8'd255)      return v;
        else if (e == 8'd254) return {v[31], 31'h7F800000};
        else if (e == 8'd0)   return {v[31], v[29:0], 1'b0};
        return {v[31], e + 8'd1, v[22:0]};
    endfunction

    function automatic logic sneg(input logic [31:0] v);
        return v[31] && (v[30:0] != 31'd0);
    endfunction

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                          input logic [31:0] z, input logic [1:0] f);
        int face;
        if (z[30:0] >= y[30:0] && z[30:0] >= x[30:0]) face = 2;
        else if (y[30:0] >= x[30:0])                  face = 1;
        else                                          face = 0;
        case (f)
            2'd0: return dbl_ref(face == 2 ? z : (face == 1 ? y : x));
            2'd1: begin
                if (face == 2) return {x[31] ^ sneg(z), x[30:0]};
                if (face == 1) return x;
                return {z[31] ^ !sneg(x), z[30:0]};
            end
            2'd2: begin
                if (face == 1) return {z[31] ^ sneg(y), z[30:0]};
                return {!y[31], y[30:0]};
            end
            default: return 32'd0;
        endcase
    endfunction

    // Driver: present one request at the falling edge and queue its expected word
    task automatic send(input logic [31:0] x, input logic [31:0] y, input logic [31:0] z,
                        input logic [1:0] f, input logic [31:0] exp, input string tag);
        @(negedge clk);
        vec_x = x; vec_y = y; vec_z = z; func_sel = f; in_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each valid result with the head of the queue
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R9: unexpected out_valid, got %08h expected none", res_data);
            end else begin
                check(tag_q.pop_front(), res_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rx, ry, rz;
        logic [1:0]  rf;
        repeat (3) @(negedge clk);
        check("R9 reset valid", {31'd0, out_valid}, 32'd0);
        check("R9 reset data", res_data, 32'd0);
        rst_n = 1'b1;

        // Latency: valid exactly one cycle after the request
        send(32'h3F800000, 32'h40000000, 32'hC0400000, 2'd0, 32'hC0C00000, "R2 z major");
        idle(1);
        check("R9 valid after req", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        check("R9 valid drops", {31'd0, out_valid}, 32'd0);

        send(32'h3F800000, 32'h40000000, 32'hC0400000, 2'd1, 32'hBF800000, "R5 z face S");
        send(32'h3F800000, 32'h40000000, 32'hC0400000, 2'd2, 32'hC0000000, "R6 z face T");
        // Ties
        send(32'hC0000000, 32'h40000000, 32'hC0000000, 2'd0, 32'hC0800000, "R1 tie to z");
        send(32'hC0A00000, 32'h40A00000, 32'h3F800000, 2'd0, 32'h41200000, "R1 tie to y");
        send(32'hC0A00000, 32'h40A00000, 32'h3F800000, 2'd1, 32'hC0A00000, "R5 y face S");
        send(32'hC0A00000, 32'h40A00000, 32'h3F800000, 2'd2, 32'h3F800000, "R6 y face T");
        // x faces
        send(32'hC0800000, 32'h3F800000, 32'h40000000, 2'd0, 32'hC1000000, "R2 x major");
        send(32'hC0800000, 32'h3F800000, 32'h40000000, 2'd1, 32'h40000000, "R5 -x face S");
        send(32'hC0800000, 32'h3F800000, 32'h40000000, 2'd2, 32'hBF800000, "R6 -x face T");
        send(32'h40400000, 32'hBF800000, 32'hBF000000, 2'd1, 32'h3F000000, "R5 +x face S");
        send(32'h40400000, 32'hBF800000, 32'hBF000000, 2'd2, 32'h3F800000, "R6 +x face T");
        // Doubling edges
        send(32'h0, 32'h0, 32'h7F7FFFFF, 2'd0, 32'h7F800000, "R3 saturate +");
        send(32'h0, 32'h0, 32'hFF000000, 2'd0, 32'hFF800000, "R3 saturate -");
        send(32'h0, 32'h0, 32'hFF800000, 2'd0, 32'hFF800000, "R3 inf pass");
        send(32'h7FC00000, 32'h3F800000, 32'h3F800000, 2'd0, 32'h7FC00000, "R3 nan pass");
        send(32'h0, 32'h0, 32'h0, 2'd0, 32'h0, "R4 zero");
        send(32'h0, 32'h0, 32'h80000000, 2'd0, 32'h80000000, "R4 neg zero");
        send(32'h00400000, 32'h0, 32'h0, 2'd0, 32'h00800000, "R4 denorm carry");
        send(32'h80000001, 32'h0, 32'h0, 2'd0, 32'h80000002, "R4 denorm neg");
        // Negative zero as sign source
        send(32'h80000000, 32'h0, 32'h80000000, 2'd1, 32'h80000000, "R7 neg zero sign");
        // Select 3
        send(32'h40400000, 32'hBF800000, 32'hBF000000, 2'd3, 32'h0, "R8 select 3");
        send(32'h3F800000, 32'h40000000, 32'hC0400000, 2'd2, 32'hC0000000, "R10 setup");
        // Hold while idle, with the operands and select changing
        @(negedge clk);
        in_valid = 1'b0;
        vec_x = 32'h12345678; vec_y = 32'h9ABCDEF0; vec_z = 32'h0F0F0F0F; func_sel = 2'd0;
        repeat (3) @(negedge clk);
        vec_y = 32'h7F000000; func_sel = 2'd1;
        @(negedge clk);
        check("R10 hold", res_data, 32'hC0000000);

        // Sweep against the reference, with forced magnitude ties
        for (int i = 0; i < 400; i++) begin
            rx = $urandom; ry = $urandom; rz = $urandom; rf = 2'($urandom);
            if (i % 4 == 1) ry = {~rx[31], rx[30:0]};
            if (i % 4 == 2) rz = {rz[31], ry[30:0]};
            if (i % 8 == 3) rx[30:23] = 8'd0;
            send(rx, ry, rz, rf, model(rx, ry, rz, rf), "R1 R5 R6 sweep");
        end
        idle(3);
        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R9: got %0d results missing expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule